// File: doc/BRIEF.md
# Fractional Multiply-Subtract with Rounding

This block performs one signed fractional multiply-subtract per accepted operation. From each of two 32-bit source words it takes either the low or the high halfword (the same half for both), multiplies the two halves as signed 16-bit numbers, and can double the product to line it up as a left-justified fraction. When the product is doubled and both halves are the most negative value, the product is pinned to the largest positive 32-bit value. The product is taken away from a signed 32-bit accumulator and half of the lower halfword's weight is added for round-to-nearest. Only the upper halfword of the outcome is kept, and the lower halfword is cleared.

A mode input picks between a wrapping result and a result clamped to the signed 32-bit range before the upper half is taken. Two flags are reported with every result. One marks a true result that does not fit in signed 32 bits. The other is the XOR of the two top bits of the wrapped 32-bit result. The inputs are registered once, so a result, and its flags, appear on the clock edge that accepts the operation and stay unchanged until the next accepted operation.

Top module: `frac_msub_rnd`

## Requirements
- R1: With `useUpper`=1 both multiplicands are bits [31:16] of `srcA` and `srcB`. With `useUpper`=0 both are bits [15:0]. They are multiplied as two's-complement signed values.
- R2: With `shiftOne`=1 the signed 32-bit product is doubled (shifted left by one) before the subtraction. With `shiftOne`=0 it is used as is.
- R3: When `shiftOne`=1 and both selected halves equal 0x8000, the product used is 0x7FFFFFFF. When `shiftOne`=0, the same operands give the plain product 0x40000000.
- R4: The exact value is accIn − product + 0x8000, computed without loss of precision. `result` bits [31:16] come from this value as selected by R5/R6, and `result` bits [15:0] are always zero.
- R5: With `satMode`=0, `result[31:16]` is bits [31:16] of the exact value taken modulo 2^32.
- R6: With `satMode`=1, the exact value is first clamped to [0x80000000, 0x7FFFFFFF]. A positive overflow therefore gives `result`=0x7FFF0000 and a negative overflow gives 0x80000000.
- R7: `ovfFlag` is 1 exactly when the exact value of R4 lies outside the signed 32-bit range, in either mode.
- R8: `advOvfFlag` equals bit 31 XOR bit 30 of the wrapped 32-bit value, taken before any saturation, in either mode.
- R9: An operation applied with `inValid`=1 at a rising clock edge is visible on `result`, `ovfFlag` and `advOvfFlag` after that same edge, and `outValid` is then 1. When `inValid`=0 the outputs hold their values, input changes are ignored, and `outValid` is 0 after the edge.
- R10: While `rstN` is low, `result`, `ovfFlag`, `advOvfFlag` and `outValid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Accept the operands on this edge |
| srcA | input | 32 | First multiplicand word |
| srcB | input | 32 | Second multiplicand word |
| accIn | input | 32 | Signed accumulator to subtract from |
| useUpper | input | 1 | 1 selects bits [31:16] of both words, 0 selects bits [15:0] |
| shiftOne | input | 1 | 1 doubles the product (fractional alignment) |
| satMode | input | 1 | 1 clamps to signed 32-bit range, 0 wraps |
| outValid | output | 1 | A result was accepted on the last edge |
| result | output | 32 | Rounded upper halfword, lower halfword zero |
| ovfFlag | output | 1 | Exact result outside signed 32-bit range |
| advOvfFlag | output | 1 | Bit 31 XOR bit 30 of the wrapped result |

## Verification
The pinned product of the minus-one-squared case and saturation can both apply to the same operation. The pinned value 0x7FFFFFFF taken from a most-negative accumulator gives a negative overflow that the clamp has to catch. A directed case sets accIn=0x80000000 with both halves at 0x8000 and `shiftOne`=1, in both output modes. The results are judged against a wide-integer bench model: 0x80000000 with the overflow flag set when clamped, and the wrapped upper half when not. Rounding carries that push a near-maximum accumulator across the positive limit are provoked the same way, and thousands of random operations cover the remaining mixes.

// File: rtl/frac_msub_pkg.sv
package frac_msub_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic capture;   // load the output registers
    logic selUpper;  // take the upper halves
    logic shiftEn;   // double the product
    logic satEn;     // clamp instead of wrap
  } ctrlStrobes_t;
endpackage

// File: rtl/frac_msub_ctrl.sv
module frac_msub_ctrl
  import frac_msub_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic         useUpper,
  input  logic         shiftOne,
  input  logic         satMode,
  output ctrlStrobes_t strobe,
  output logic         outValid
);
  always_comb begin
    strobe.capture  = inValid;
    strobe.selUpper = useUpper;
    strobe.shiftEn  = shiftOne;
    strobe.satEn    = satMode;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end
endmodule

// File: rtl/frac_msub_dp.sv
module frac_msub_dp
  import frac_msub_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobe,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic [DATA_W-1:0] accIn,
  output logic [DATA_W-1:0] resultQ,
  output logic              ovfQ,
  output logic              advOvfQ
);
  localparam int HALF_W = DATA_W / 2;
  localparam int EXT_W  = DATA_W + 2;
  localparam logic [HALF_W-1:0] MIN_HALF  = {1'b1, {(HALF_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] MAX_WORD  = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] MIN_WORD  = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [EXT_W-1:0]  ROUND_K   = EXT_W'(1) << (HALF_W - 1);
  localparam logic [EXT_W-1:0]  PIN_PROD  = {2'b00, MAX_WORD};

  logic [DATA_W-1:0] srcWord [2];
  logic [HALF_W-1:0] opHalf  [2];

  assign srcWord[0] = srcA;
  assign srcWord[1] = srcB;

  // Same half of both words
  for (genvar gi = 0; gi < 2; gi++) begin : g_half
    assign opHalf[gi] = strobe.selUpper ? srcWord[gi][DATA_W-1:HALF_W]
                                        : srcWord[gi][HALF_W-1:0];
  end

  logic signed [DATA_W-1:0] rawProd;
  logic                     cornerHit;
  logic [EXT_W-1:0]         prodExt;
  logic [EXT_W-1:0]         accExt;
  logic [EXT_W-1:0]         exactSum;
  logic [2:0]               topBits;
  logic                     ovfNow;
  logic [DATA_W-1:0]        wrapVal;
  logic [DATA_W-1:0]        satVal;
  logic [DATA_W-1:0]        pickVal;

  assign rawProd   = $signed(opHalf[0]) * $signed(opHalf[1]);
  assign cornerHit = strobe.shiftEn && (opHalf[0] == MIN_HALF) && (opHalf[1] == MIN_HALF);

  always_comb begin
    if (cornerHit)
      prodExt = PIN_PROD;
    else if (strobe.shiftEn)
      prodExt = {rawProd[DATA_W-1], rawProd, 1'b0};
    else
      prodExt = {{2{rawProd[DATA_W-1]}}, rawProd};
  end

  assign accExt   = {{2{accIn[DATA_W-1]}}, accIn};
  assign exactSum = accExt - prodExt + ROUND_K;
  assign topBits  = exactSum[EXT_W-1:DATA_W-1];
  assign ovfNow   = !((topBits == 3'b000) || (topBits == 3'b111));
  assign wrapVal  = exactSum[DATA_W-1:0];

  always_comb begin
    if (!ovfNow)                 satVal = wrapVal;
    else if (exactSum[EXT_W-1])  satVal = MIN_WORD;
    else                         satVal = MAX_WORD;
  end

  assign pickVal = strobe.satEn ? satVal : wrapVal;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultQ <= '0;
      ovfQ    <= 1'b0;
      advOvfQ <= 1'b0;
    end else if (strobe.capture) begin
      resultQ <= {pickVal[DATA_W-1:HALF_W], {HALF_W{1'b0}}};
      ovfQ    <= ovfNow;
      advOvfQ <= wrapVal[DATA_W-1] ^ wrapVal[DATA_W-2];
    end
  end
endmodule

// File: rtl/frac_msub_rnd.sv
module frac_msub_rnd
  import frac_msub_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic [DATA_W-1:0] accIn,
  input  logic              useUpper,
  input  logic              shiftOne,
  input  logic              satMode,
  output logic              outValid,
  output logic [DATA_W-1:0] result,
  output logic              ovfFlag,
  output logic              advOvfFlag
);
  ctrlStrobes_t strobe;

  frac_msub_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .useUpper (useUpper),
    .shiftOne (shiftOne),
    .satMode  (satMode),
    .strobe   (strobe),
    .outValid (outValid)
  );

  frac_msub_dp #(.DATA_W(DATA_W)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .srcA    (srcA),
    .srcB    (srcB),
    .accIn   (accIn),
    .resultQ (result),
    .ovfQ    (ovfFlag),
    .advOvfQ (advOvfFlag)
  );
endmodule

// File: rtl/frac_msub_chk.sv
module frac_msub_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              satMode,
  input logic              outValid,
  input logic [DATA_W-1:0] result,
  input logic              ovfFlag,
  input logic              advOvfFlag
);
  localparam int HALF_W = DATA_W / 2;
  localparam logic [DATA_W-1:0] TOP_CLAMP = {1'b0, {(HALF_W-1){1'b1}}, {HALF_W{1'b0}}};
  localparam logic [DATA_W-1:0] BOT_CLAMP = {1'b1, {(DATA_W-1){1'b0}}};

  // R4
  low_half_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    result[HALF_W-1:0] == '0);

  // R9
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(result) && $stable(ovfFlag) && $stable(advOvfFlag) && !outValid));

  // R6
  sat_clamp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && satMode) |=> (!ovfFlag || result == TOP_CLAMP || result == BOT_CLAMP));

  // R8
  adv_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !satMode) |=> (advOvfFlag == (result[DATA_W-1] ^ result[DATA_W-2])));
endmodule

bind frac_msub_rnd frac_msub_chk #(.DATA_W(DATA_W)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .inValid    (inValid),
  .satMode    (satMode),
  .outValid   (outValid),
  .result     (result),
  .ovfFlag    (ovfFlag),
  .advOvfFlag (advOvfFlag)
);

// File: tb/frac_msub_rnd_tb_top.sv
module frac_msub_rnd_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] srcA = '0, srcB = '0, accIn = '0;
  logic        useUpper = 1'b0, shiftOne = 1'b0, satMode = 1'b0;
  logic        outValid, ovfFlag, advOvfFlag;
  logic [31:0] result;

  int total = 0;
  int bad = 0;
  bit doneFlag = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frac_msub_rnd dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .srcA(srcA), .srcB(srcB),
    .accIn(accIn), .useUpper(useUpper), .shiftOne(shiftOne), .satMode(satMode),
    .outValid(outValid), .result(result), .ovfFlag(ovfFlag), .advOvfFlag(advOvfFlag)
  );

  // Expected {ovf, adv, result} from the requirements
  function automatic logic [33:0] refModel(input logic [31:0] a, input logic [31:0] b,
                                           input logic [31:0] acc, input logic up,
                                           input logic sh, input logic sat);
    shortint ha, hb;
    int      accS;
    longint  prod, ex;
    logic [31:0] w, v;
    logic    ov;
    ha = up ? a[31:16] : a[15:0];
    hb = up ? b[31:16] : b[15:0];
    prod = longint'(ha) * longint'(hb);
    if (sh) begin
      if (ha == -16'sd32768 && hb == -16'sd32768) prod = 64'sd2147483647;
      else prod = prod * 2;
    end
    accS = acc;
    ex = longint'(accS) - prod + 64'sd32768;
    ov = (ex > 64'sd2147483647) || (ex < -64'sd2147483648);
    w  = ex[31:0];
    if (sat && ov) v = (ex < 0) ? 32'h8000_0000 : 32'h7FFF_FFFF;
    else v = w;
    return {ov, w[31] ^ w[30], v[31:16], 16'h0000};
  endfunction

  task automatic checkOut(input string tag, input logic [33:0] exp);
    total++;
    if ({ovfFlag, advOvfFlag, result} !== exp || outValid !== 1'b1) begin
      bad++;
      $display("FAIL %s: got ovf=%0b adv=%0b res=%08h vld=%0b, expected ovf=%0b adv=%0b res=%08h vld=1",
               tag, ovfFlag, advOvfFlag, result, outValid, exp[33], exp[32], exp[31:0]);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge after checking
  task automatic runOp(input string tag, input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] acc, input logic up, input logic sh, input logic sat);
    logic [33:0] exp;
    srcA = a; srcB = b; accIn = acc; useUpper = up; shiftOne = sh; satMode = sat;
    inValid = 1'b1;
    exp = refModel(a, b, acc, up, sh, sat);
    @(negedge clk);
    inValid = 1'b0;
    checkOut(tag, exp);
  endtask

  initial begin
    logic [33:0] held;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R10
    total++;
    if (result !== 32'h0 || ovfFlag !== 1'b0 || advOvfFlag !== 1'b0 || outValid !== 1'b0) begin
      bad++;
      $display("FAIL R10: got res=%08h ovf=%0b adv=%0b vld=%0b, expected all 0",
               result, ovfFlag, advOvfFlag, outValid);
    end
    rstN = 1'b1;
    @(negedge clk);

    // R3 pinned product with doubling, plain product without
    runOp("R3 pin n=1", 32'h0000_8000, 32'h0000_8000, 32'h0, 1'b0, 1'b1, 1'b0);
    runOp("R3 n=0",     32'h0000_8000, 32'h0000_8000, 32'h0, 1'b0, 1'b0, 1'b0);
    // R1 half select, upper differs from lower
    runOp("R1 upper",   32'hC000_1234, 32'h2000_7FFF, 32'h1234_5678, 1'b1, 1'b0, 1'b0);
    runOp("R1 lower",   32'hC000_1234, 32'h2000_7FFF, 32'h1234_5678, 1'b0, 1'b0, 1'b0);
    // R2 doubling
    runOp("R2 shift",   32'h0000_4000, 32'h0000_C000, 32'h0, 1'b0, 1'b1, 1'b0);
    // R4 rounding at half LSB
    runOp("R4 below half", 32'h0, 32'h0, 32'h0000_7FFF, 1'b0, 1'b0, 1'b0);
    runOp("R4 at half",    32'h0, 32'h0, 32'h0000_8000, 1'b0, 1'b0, 1'b0);
    runOp("R4 neg half",   32'h0, 32'h0, 32'hFFFF_8000, 1'b0, 1'b0, 1'b0);
    // R5/R6/R7/R8 positive overflow, wrap then clamp
    runOp("R5 R7 R8 pos wrap", 32'h0000_0001, 32'h0000_FFFF, 32'h7FFF_FFFF, 1'b0, 1'b0, 1'b0);
    runOp("R6 R7 pos sat",     32'h0000_0001, 32'h0000_FFFF, 32'h7FFF_FFFF, 1'b0, 1'b0, 1'b1);
    runOp("R6 R7 round sat",   32'h0, 32'h0, 32'h7FFF_9000, 1'b0, 1'b0, 1'b1);
    // R3 + R6 together: pinned product from most negative accumulator
    runOp("R3 R6 neg sat",     32'h8000_0000, 32'h8000_0000, 32'h8000_0000, 1'b1, 1'b1, 1'b1);
    runOp("R3 R5 neg wrap",    32'h8000_0000, 32'h8000_0000, 32'h8000_0000, 1'b1, 1'b1, 1'b0);

    // R9 idle inputs ignored
    held = {ovfFlag, advOvfFlag, result};
    srcA = 32'h1111_2222; srcB = 32'h7FFF_7FFF; accIn = 32'h0BAD_F00D; satMode = 1'b0;
    @(negedge clk);
    total++;
    if ({ovfFlag, advOvfFlag, result} !== held || outValid !== 1'b0) begin
      bad++;
      $display("FAIL R9 hold: got ovf=%0b adv=%0b res=%08h vld=%0b, expected ovf=%0b adv=%0b res=%08h vld=0",
               ovfFlag, advOvfFlag, result, outValid, held[33], held[32], held[31:0]);
    end

    // Random mix: R1 R2 R4 R5 R6 R7 R8
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] ra, rb, rc;
      ra = $urandom(); rb = $urandom(); rc = $urandom();
      if ($urandom_range(0, 7) == 0) ra[15:0] = 16'h8000;
      if ($urandom_range(0, 7) == 0) rb[15:0] = 16'h8000;
      if ($urandom_range(0, 3) == 0) rc = {rc[31], {15{rc[31] ? 1'b0 : 1'b1}}, rc[15:0]};
      runOp("R1 R2 R4 R5 R6 R7 R8 random", ra, rb, rc,
            1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      if ($urandom_range(0, 3) == 0) @(negedge clk);
    end

    doneFlag = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!doneFlag) begin
      total++;
      bad++;
      $display("FAIL watchdog: got no completion, expected finish before timeout");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule